// File: doc/BRIEF.md
# Channel Health Monitor

This block watches one received channel and folds four fault sources into a single card-error flag. Two of the sources are built in. An activity watchdog is a down counter on the system clock; every input timing strobe reloads it, and it flags a fault when it reaches zero. A redundancy comparator checks two copies of the received data, which come from separate receivers. The other two sources are external fault levels. They may arrive from any clock domain, so each is passed through a two-flop synchronizer.

The flag is not given a pin of its own on the outgoing frame. It shares the active-low positive-stuff request line. While the frame's word-24, bit-0 slot strobe is high, the line carries the inverted card error. In every other cycle it carries the inverted stuff request. All pins are plain level or strobe controls. There is no data stream at this boundary, so no valid/ready handshake applies and no back-pressure exists.

Top module: `chan_health_mon`

## Requirements
- R1: While `rst_n` is low, `pstuff_n` is 1 and `card_err` is 0.
- R2: In a cycle where `slot_w24b0` is 0, `pstuff_n` at the next cycle equals the inverse of `pstuff_req`. An active fault never appears on the line in such a cycle.
- R3: In a cycle where `slot_w24b0` is 1, `pstuff_n` at the next cycle equals the inverse of `card_err` at that same next cycle. `pstuff_req` has no effect in that cycle.
- R4: If no `tstrobe` arrives for `TMO_CYCLES` clock edges after the last one, `card_err` rises. If the last strobe is sampled at cycle c, `card_err` is 0 at cycle c+1+TMO_CYCLES and 1 at cycle c+2+TMO_CYCLES. A new strobe at cycle d clears this source, so `card_err` is 0 at cycle d+2.
- R5: While strobes keep arriving with gaps shorter than `TMO_CYCLES`, the watchdog never contributes a fault.
- R6: The comparator looks at `rx_copy_a` and `rx_copy_b` only in a cycle where `tstrobe` is high. A mismatch sampled at cycle c makes `card_err` 1 at cycle c+2. A mismatch in a cycle without a strobe is ignored.
- R7: A comparator fault is held until a strobe samples matching copies at cycle s. `card_err` is then 0 at cycle s+2, provided no other fault is active.
- R8: Each bit of `ext_fault` passes through two synchronizing flops. A level applied at cycle c appears in `card_err` at cycle c+3 and not yet at cycle c+2. The same latency applies when the level is removed.
- R9: `card_err` is the OR of the four sources: watchdog, comparator, `ext_fault[0]` and `ext_fault[1]`. Any single one raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tstrobe | input | 1 | Input timing strobe, one-cycle pulse in the clk domain |
| rx_copy_a | input | 1 | Received data, first receiver |
| rx_copy_b | input | 1 | Received data, redundant receiver |
| ext_fault | input | N_EXT | External fault levels, asynchronous |
| slot_w24b0 | input | 1 | High during the word-24, bit-0 slot |
| pstuff_req | input | 1 | Positive-stuff request, active high |
| pstuff_n | output | 1 | Shared active-low stuff/fault line, registered |
| card_err | output | 1 | Combined fault flag, registered |

## Verification
The properties assume the following about the inputs:
- `tstrobe` is a single-cycle pulse in the `clk` domain.
- Both receiver copies are settled in any cycle where the strobe is high.
- The slot strobe and stuff request are synchronous to `clk`.

The stimulus drives every input on the falling edge. During normal running it spaces strobes four cycles apart, well inside the timeout. It breaks that pattern only once, to stall the strobe on purpose. External fault levels are held for at least five cycles, so the synchronizer sees each one as a clean level. Receiver mismatches are placed both on strobe cycles and between strobes, to tell sampled faults from ignored ones.

// File: rtl/chm_pkg.sv
package chm_pkg;
  // Bit positions of the fault sources inside the combined vector
  localparam int SRC_ACT  = 0;
  localparam int SRC_CMP  = 1;
  localparam int EXT_BASE = 2;
endpackage

// File: rtl/chm_sync.sv
module chm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

  // R8: output stage always follows the previous stage by one clock
  a_r8_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q == $past(st[STAGES-2]));
endmodule

// File: rtl/chm_watchdog.sv
module chm_watchdog #(
  parameter int CNT_W = 16,
  parameter int TMO   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic dead
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TMO);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= LOAD;
    else if (strobe)       cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign dead = (cnt == '0);

  // R4: a strobe always clears the activity fault on the next cycle
  a_r4_strobe_revives: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !dead);
  // R4: once flagged, the fault stays until a strobe arrives
  a_r4_dead_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    dead && !strobe |=> dead);
  // R5: without a strobe the counter only moves downward by one
  a_r5_steady_descent: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe && !dead |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/chm_compare.sv
module chm_compare (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic copy_a,
  input  logic copy_b,
  output logic mismatch
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mismatch <= 1'b0;
    else if (strobe) mismatch <= copy_a ^ copy_b;
  end

  // R6: the flag reflects the copies as seen on the strobe cycle
  a_r6_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> mismatch == ($past(copy_a) != $past(copy_b)));
  // R7: between strobes the flag cannot change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(mismatch));
endmodule

// File: rtl/chan_health_mon.sv
module chan_health_mon
  import chm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TMO_CYCLES = 1000,
  parameter int N_EXT      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tstrobe,
  input  logic             rx_copy_a,
  input  logic             rx_copy_b,
  input  logic [N_EXT-1:0] ext_fault,
  input  logic             slot_w24b0,
  input  logic             pstuff_req,
  output logic             pstuff_n,
  output logic             card_err
);
  localparam int NSRC = EXT_BASE + N_EXT;

  logic             act_dead;
  logic             cmp_bad;
  logic [N_EXT-1:0] ext_s;
  logic [NSRC-1:0]  src;
  logic             any_fault;

  chm_watchdog #(.CNT_W(CNT_W), .TMO(TMO_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .strobe(tstrobe), .dead(act_dead));

  chm_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .strobe(tstrobe),
    .copy_a(rx_copy_a), .copy_b(rx_copy_b), .mismatch(cmp_bad));

  chm_sync #(.W(N_EXT), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_fault), .q(ext_s));

  always_comb begin
    src                       = '0;
    src[SRC_ACT]              = act_dead;
    src[SRC_CMP]              = cmp_bad;
    src[NSRC-1:EXT_BASE]      = ext_s;
    any_fault                 = |src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstuff_n <= 1'b1;
      card_err <= 1'b0;
    end else begin
      card_err <= any_fault;
      pstuff_n <= slot_w24b0 ? ~any_fault : ~pstuff_req;
    end
  end

  // R2: outside the slot the line mirrors the stuff request
  a_r2_stuff_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_w24b0 |=> pstuff_n == !$past(pstuff_req));
  // R3: inside the slot the line carries the fault flag
  a_r3_slot_fault: assert property (@(posedge clk) disable iff (!rst_n)
    slot_w24b0 |=> pstuff_n == !card_err);
  // R9: any watchdog or comparator fault shows on the flag one clock later
  a_r9_internal_or: assert property (@(posedge clk) disable iff (!rst_n)
    (act_dead || cmp_bad) |=> card_err);
endmodule

// File: tb/chan_health_mon_test.sv
module chan_health_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 20;

  typedef struct {
    int    cyc;
    logic  pn;
    logic  ce;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tstrobe = 1'b0, rx_a = 1'b0, rx_b = 1'b0, slot = 1'b0, req = 1'b0;
  logic [1:0] ext = 2'b00;
  logic       pstuff_n, card_err;

  int   cyc = 0;
  int   ph = 0;
  int   n_chk = 0, n_fail = 0;
  exp_t sb[$];

  chan_health_mon #(.CNT_W(16), .TMO_CYCLES(TMO), .N_EXT(2)) uut (
    .clk(clk), .rst_n(rst_n), .tstrobe(tstrobe), .rx_copy_a(rx_a),
    .rx_copy_b(rx_b), .ext_fault(ext), .slot_w24b0(slot),
    .pstuff_req(req), .pstuff_n(pstuff_n), .card_err(card_err));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {pstuff_n,card_err} got %b expected %b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic push(input int c, input logic pn, input logic ce, input string tag);
    exp_t e;
    e.cyc = c; e.pn = pn; e.ce = ce; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares outputs with every expectation due this cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          chk(sb[i].tag, {pstuff_n, card_err}, {sb[i].pn, sb[i].ce});
          sb.delete(i);
        end
      end
    end
  end

  task automatic step(input logic s, input logic a, input logic b,
                      input logic [1:0] e, input logic sl, input logic rq);
    @(negedge clk);
    tstrobe = s; rx_a = a; rx_b = b; ext = e; slot = sl; req = rq;
  endtask

  task automatic tick(input logic [1:0] e, input logic sl, input logic rq);
    step((ph % 4) == 0, 1'b0, 1'b0, e, sl, rq);
    ph++;
  endtask

  task automatic run(input int n, input bit check);
    for (int i = 0; i < n; i++) begin
      tick(2'b00, 1'b0, 1'b0);
      if (check) push(cyc + 1, 1'b1, 1'b0, "R5");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {pstuff_n, card_err}, 2'b10);
    req = 1'b1; slot = 1'b1; ext = 2'b11;
    @(negedge clk);
    chk("R1", {pstuff_n, card_err}, 2'b10);
    req = 1'b0; slot = 1'b0; ext = 2'b00;
    rst_n = 1'b1;
    run(8, 1'b1);

    // R2: request pass-through outside the slot
    tick(2'b00, 1'b0, 1'b1); push(cyc + 1, 1'b0, 1'b0, "R2");
    tick(2'b00, 1'b0, 1'b0); push(cyc + 1, 1'b1, 1'b0, "R2");
    tick(2'b00, 1'b0, 1'b1); push(cyc + 1, 1'b0, 1'b0, "R2");
    tick(2'b00, 1'b0, 1'b1); push(cyc + 1, 1'b0, 1'b0, "R2");
    // R3: request ignored in the slot when healthy
    tick(2'b00, 1'b1, 1'b1); push(cyc + 1, 1'b1, 1'b0, "R3");
    run(4, 1'b1);

    // R8/R9: each external fault in turn
    for (int i = 0; i < 2; i++) begin
      logic [1:0] e;
      e = 2'b01 << i;
      tick(e, 1'b0, 1'b0); c = cyc;
      push(c + 2, 1'b1, 1'b0, "R8");
      push(c + 3, 1'b1, 1'b1, "R9");
      tick(e, 1'b0, 1'b0);
      tick(e, 1'b0, 1'b0);
      tick(e, 1'b1, 1'b0); push(c + 4, 1'b0, 1'b1, "R3");
      tick(e, 1'b0, 1'b0); push(c + 5, 1'b1, 1'b1, "R2");
      tick(2'b00, 1'b0, 1'b0);
      push(c + 7, 1'b1, 1'b1, "R8");
      push(c + 8, 1'b1, 1'b0, "R8");
      run(4, 1'b0);
      run(4, 1'b1);
    end

    // R6: mismatch between strobes ignored, mismatch on a strobe flagged
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0); c = cyc;
    push(c + 1, 1'b1, 1'b0, "R6"); push(c + 2, 1'b1, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    push(cyc + 2, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0); c = cyc;
    push(c + 1, 1'b1, 1'b0, "R6"); push(c + 2, 1'b1, 1'b1, "R6");
    // R7: hold until a matching strobe
    step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0); push(cyc + 1, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0); push(cyc + 1, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0); c = cyc;
    push(c + 1, 1'b1, 1'b1, "R7"); push(c + 2, 1'b1, 1'b0, "R7");
    ph = 1;
    run(6, 1'b1);

    // R4: strobe stall, fault in the slot, recovery
    step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0); c = cyc;
    push(c + 1 + TMO, 1'b1, 1'b0, "R4");
    push(c + 2 + TMO, 1'b1, 1'b1, "R4");
    push(c + 3 + TMO, 1'b0, 1'b1, "R3");
    for (int i = 1; i <= TMO + 3; i++)
      step(1'b0, 1'b0, 1'b0, 2'b00, (i == TMO + 2), 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0); c = cyc;
    push(c + 1, 1'b1, 1'b1, "R4");
    push(c + 2, 1'b1, 1'b0, "R4");
    ph = 1;
    run(10, 1'b1);

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail += sb.size();
      $display("FAIL scoreboard: got %0d unchecked items expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule